// File: doc/BRIEF.md
# Tiled Mosaic Frame-Buffer Address Sequencer

This block drives the address side of a frame buffer that holds one large image and feeds nine display channels. The image is cut into a grid of equal tiles. By default the grid is three tiles across and three tiles down. Each tile is 640 by 480 pixels and each stored pixel is 16 bits. Tile n feeds output channel n.

For every pixel position inside a tile, the sequencer issues one read to each tile in turn, so all nine channels advance in step. The positions are taken left to right, then top to bottom. Each read carries a tile tag, which a downstream demultiplexer uses to steer the returned data to its channel.

Incoming pixels are written to the same memory through a linear raster write address. A small state machine decides each cycle whether the memory slot goes to a write, a read, or nothing.

The state machine has three states:
- `ST_IDLE`: no access this cycle.
- `ST_WRITE`: a write address is presented.
- `ST_READ`: a read address and its tag are presented.

The next state is chosen from the inputs sampled at the edge, not from the current state:
- `ST_WRITE` whenever `wr_req` is high.
- `ST_READ` when only `rd_en` is high.
- `ST_IDLE` otherwise.

Reset places the machine in `ST_IDLE`.

Top module: `mosaic_addr_gen`

## Requirements
- R1: After reset, `mem_we`, `rd_valid` and `frame_done` are 0. The first read issued is address 0 with tag 0, and the first write issued is address 0.
- R2: Reads cycle through the tiles 0 to 8 at one pixel position, then move to the next position. Positions advance x first, then y, inside the tile.
- R3: The read address is (trow*TILE_H + y)*IMG_W + tcol*TILE_W + x, where IMG_W = TILE_W*GRID_C. Here trow = tile / GRID_C and tcol = tile % GRID_C.
- R4: `rd_tile` is the 4-bit tile number, counted in row-major order over the grid, starting at 0 in the top-left tile.
- R5: When `wr_req` and `rd_en` are both high, the write is issued. The pending read is then issued later with no tile, position or address skipped.
- R6: When neither request is high, the next cycle shows `mem_we` = 0 and `rd_valid` = 0, and no read or write counter moves.
- R7: Successive writes use addresses 0, 1, 2 and so on up to IMG_W*IMG_H-1, then wrap back to 0.
- R8: `frame_done` is 1 for exactly the one cycle that presents the last read of the frame: tile 8, x = TILE_W-1, y = TILE_H-1. The next read is address 0 with tag 0.
- R9: A request sampled at a rising edge is presented on the outputs for the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | An incoming pixel wants a write slot |
| rd_en | input | 1 | The read sequence may take a slot |
| mem_addr | output | ADDR_W | Memory address for this cycle |
| mem_we | output | 1 | This cycle is a write |
| rd_valid | output | 1 | This cycle is a read |
| rd_tile | output | TAG_W | Tile tag of the read |
| frame_done | output | 1 | Last read of the frame is presented |

## Verification
The assertions take the requests to be level inputs that are sampled once per edge, with no handshake. A request that is not taken simply waits, so `rd_en` may stay high across write cycles without losing a read. The stimulus changes the inputs only at the falling edge and never holds `rd_en` while it checks idle cycles. The bench shrinks the tiles so that a whole frame of reads and a full write wrap fit into a short run. It uses the same 3x3 grid, so the tag and ordering rules are exercised unchanged.

// File: rtl/mosaic_pkg.sv
package mosaic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } slot_state_t;
endpackage

// File: rtl/mosaic_rd_seq.sv
module mosaic_rd_seq #(
    parameter int TILE_W = 640,
    parameter int TILE_H = 480,
    parameter int GRID_C = 3,
    parameter int GRID_R = 3,
    parameter int ADDR_W = 22,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tile,
    output logic              last
);
    localparam int NT    = GRID_C * GRID_R;
    localparam int IMG_W = TILE_W * GRID_C;
    localparam int XW    = (TILE_W > 1) ? $clog2(TILE_W) : 1;
    localparam int YW    = (TILE_H > 1) ? $clog2(TILE_H) : 1;
    localparam int CW    = (GRID_C > 1) ? $clog2(GRID_C) : 1;
    localparam int RW    = (GRID_R > 1) ? $clog2(GRID_R) : 1;

    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [CW-1:0] tcol_q;
    logic [RW-1:0] trow_q;
    logic [TAG_W-1:0] tile_q;

    wire col_end = (tcol_q == CW'(GRID_C - 1));
    wire row_end = (trow_q == RW'(GRID_R - 1));
    wire x_end   = (x_q == XW'(TILE_W - 1));
    wire y_end   = (y_q == YW'(TILE_H - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            tcol_q <= '0;
            trow_q <= '0;
            tile_q <= '0;
        end else if (adv) begin
            if (!col_end) begin
                tcol_q <= tcol_q + 1'b1;
                tile_q <= tile_q + 1'b1;
            end else begin
                tcol_q <= '0;
                if (!row_end) begin
                    trow_q <= trow_q + 1'b1;
                    tile_q <= tile_q + 1'b1;
                end else begin
                    trow_q <= '0;
                    tile_q <= '0;
                    if (!x_end) begin
                        x_q <= x_q + 1'b1;
                    end else begin
                        x_q <= '0;
                        y_q <= y_end ? '0 : y_q + 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        addr = (ADDR_W'(trow_q) * ADDR_W'(TILE_H) + ADDR_W'(y_q)) * ADDR_W'(IMG_W)
             + ADDR_W'(tcol_q) * ADDR_W'(TILE_W) + ADDR_W'(x_q);
        tile = tile_q;
        last = col_end && row_end && x_end && y_end;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(tile_q) && $stable(x_q) && $stable(y_q))); // R5
    AST_TILE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && tile_q != TAG_W'(NT - 1)) |=> (tile_q == $past(tile_q) + 1'b1)); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> (addr == '0 && tile_q == '0)); // R8
endmodule

// File: rtl/mosaic_wr_seq.sv
module mosaic_wr_seq #(
    parameter int PIXELS = 2764800,
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= (cnt_q == ADDR_W'(PIXELS - 1)) ? '0 : cnt_q + 1'b1;
    end

    assign addr = cnt_q;

    AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q == ADDR_W'(PIXELS - 1)) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/mosaic_addr_gen.sv
module mosaic_addr_gen
    import mosaic_pkg::*;
#(
    parameter int TILE_W = 640,
    parameter int TILE_H = 480,
    parameter int GRID_C = 3,
    parameter int GRID_R = 3,
    parameter int ADDR_W = $clog2(TILE_W * GRID_C * TILE_H * GRID_R),
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tile,
    output logic              frame_done
);
    localparam int NT     = GRID_C * GRID_R;
    localparam int PIXELS = TILE_W * GRID_C * TILE_H * GRID_R;

    slot_state_t state_q, state_d;
    logic [ADDR_W-1:0] rd_addr, wr_addr, addr_q;
    logic [TAG_W-1:0]  rd_tag, tag_q;
    logic              rd_last, fd_q;
    logic              take_wr, take_rd;

    assign take_wr = wr_req;
    assign take_rd = rd_en && !wr_req;

    mosaic_rd_seq #(
        .TILE_W(TILE_W), .TILE_H(TILE_H), .GRID_C(GRID_C), .GRID_R(GRID_R),
        .ADDR_W(ADDR_W), .TAG_W(TAG_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .adv(take_rd),
        .addr(rd_addr), .tile(rd_tag), .last(rd_last)
    );

    mosaic_wr_seq #(.PIXELS(PIXELS), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .adv(take_wr), .addr(wr_addr)
    );

    always_comb begin
        if (take_wr)      state_d = ST_WRITE;
        else if (take_rd) state_d = ST_READ;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            tag_q   <= '0;
            fd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= take_wr ? wr_addr : rd_addr;
            tag_q   <= rd_tag;
            fd_q    <= take_rd && rd_last;
        end
    end

    always_comb begin
        mem_we     = 1'b0;
        rd_valid   = 1'b0;
        rd_tile    = '0;
        frame_done = 1'b0;
        mem_addr   = addr_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: mem_we = 1'b1;
            ST_READ: begin
                rd_valid   = 1'b1;
                rd_tile    = tag_q;
                frame_done = fd_q;
            end
            default:  ;
        endcase
    end

    AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (mem_we && !rd_valid)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !rd_en) |=> (!mem_we && !rd_valid)); // R6
    AST_RD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_req) |=> rd_valid); // R9
    AST_FD_LAST_TILE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (rd_valid && rd_tile == TAG_W'(NT - 1))); // R8
    AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_tile < TAG_W'(NT))); // R4
endmodule

// File: tb/tb_mosaic_addr_gen.sv
module tb_mosaic_addr_gen;
    localparam int TW = 4, TH = 2, GC = 3, GR = 3;
    localparam int NT = GC * GR;
    localparam int IW = TW * GC;
    localparam int PIX = IW * TH * GR;
    localparam int AW = $clog2(PIX);
    localparam int NV = 14;
    // {wr, rd, exp_we, exp_valid, exp_addr[7:0], exp_tile[3:0]}
    localparam logic [15:0] VEC [NV] = '{
        {4'b0101, 8'd0,  4'd0},  // R1 R9 first read
        {4'b0101, 8'd4,  4'd1},  // R2 R4
        {4'b1010, 8'd0,  4'd0},  // R1 first write
        {4'b1110, 8'd1,  4'd0},  // R5 write wins
        {4'b0101, 8'd8,  4'd2},  // R5 no skip
        {4'b0000, 8'd0,  4'd0},  // R6 idle
        {4'b0101, 8'd24, 4'd3},  // R3
        {4'b0101, 8'd28, 4'd4},
        {4'b0101, 8'd32, 4'd5},
        {4'b0101, 8'd48, 4'd6},
        {4'b0101, 8'd52, 4'd7},
        {4'b1010, 8'd2,  4'd0},  // R7
        {4'b0101, 8'd56, 4'd8},
        {4'b0101, 8'd1,  4'd0}   // R2 next x
    };

    logic clk = 0, rst_n = 0, wr_req = 0, rd_en = 0;
    logic [AW-1:0] mem_addr;
    logic mem_we, rd_valid, frame_done;
    logic [3:0] rd_tile;
    int checks = 0, errors = 0, nrd = 0, nwr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mosaic_addr_gen #(.TILE_W(TW), .TILE_H(TH), .GRID_C(GC), .GRID_R(GR)) dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_en(rd_en),
        .mem_addr(mem_addr), .mem_we(mem_we), .rd_valid(rd_valid),
        .rd_tile(rd_tile), .frame_done(frame_done));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rd_addr_of(input int n);
        int t = n % NT, p = n / NT;
        return ((t / GC) * TH + p / TW) * IW + (t % GC) * TW + p % TW;
    endfunction

    task automatic cyc(input logic w, input logic r);
        @(negedge clk);
        wr_req = w; rd_en = r;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 we", mem_we, 0);
        chk("R1 valid", rd_valid, 0);
        chk("R1 frame_done", frame_done, 0);
        @(negedge clk) rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][15], VEC[i][14]);
            chk("R9 R5 R6 we", mem_we, VEC[i][13]);
            chk("R9 R6 valid", rd_valid, VEC[i][12]);
            if (VEC[i][13] || VEC[i][12]) chk("R3 R7 addr", mem_addr, VEC[i][11:4]);
            if (VEC[i][12]) chk("R4 tile", rd_tile, VEC[i][3:0]);
            nrd += VEC[i][12];
            nwr += VEC[i][13];
        end
        // R2 R3 R8: remainder of the frame plus the wrap
        while (nrd <= PIX) begin
            cyc(0, 1);
            chk("R3 addr", mem_addr, rd_addr_of(nrd % PIX));
            chk("R4 tile", rd_tile, (nrd % PIX) % NT);
            chk("R8 frame_done", frame_done, (nrd == PIX - 1) ? 1 : 0);
            nrd++;
        end
        // R7: writes up to the wrap
        while (nwr <= PIX) begin
            cyc(1, 1);
            chk("R7 waddr", mem_addr, nwr % PIX);
            chk("R5 valid", rd_valid, 0);
            nwr++;
        end
        cyc(0, 1);
        chk("R5 resume addr", mem_addr, rd_addr_of(1));
        // R1: reset mid-run
        @(negedge clk) rst_n = 0; wr_req = 0; rd_en = 0;
        #2 chk("R1 we async", mem_we, 0);
        chk("R1 valid async", rd_valid, 0);
        @(negedge clk) rst_n = 1;
        cyc(0, 1);
        chk("R1 addr after reset", mem_addr, 0);
        chk("R1 tile after reset", rd_tile, 0);
        cyc(1, 0);
        chk("R1 waddr after reset", mem_addr, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule